// File: doc/BRIEF.md
# Vector-Length Element Issue Stage

This stage sits between an instruction decoder and a scheduler. It takes one decoded instruction per handshake and turns it into element groups on a valid/ready stream. Each group carries a starting element index and a lane mask that is up to `ISSUE_W` lanes wide. The stage decides whether to loop over the vector length by ORing the operand vector markers that belong to the instruction's operand count. Instructions without any vector operand are passed through once and never look at the vector length. Vector instructions are split into ascending groups. A vector instruction that meets a vector length of zero is discarded inside the stage.

The stage also owns the vector-length register. When an instruction loads the length from an immediate, the new value applies to the very next instruction with no bubble. When an instruction loads the length from a register, the stage issues that instruction and then holds all later input until the executed value is written back. A flush input throws away any loop in progress, any pending output and any write-back wait.

Top module: `vl_loop_stage`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the vector length is 0.
- R2: An instruction counts as vector when any of `in_vbits[in_nregs-1:0]` is set. Bit i belongs to register operand i. Bits at or above `in_nregs` are ignored, and `in_nregs` = 0 means scalar. Instructions that load the length are always scalar.
- R3: A scalar instruction produces exactly one group with `out_base` = 0, `out_mask` = 0001 (lane 0 only) and `out_vector` = 0, whatever the vector length is, zero included.
- R4: A vector instruction accepted while the vector length is 0 produces no group.
- R5: A vector instruction with length L produces groups with bases 0, W, 2W and so on, in ascending order, while base < L. Mask bit i of a group is set exactly when base+i < L. Every group carries `out_vector` = 1 and the instruction's tag.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_base`, `out_mask`, `out_tag` and `out_vector` hold their values and no group is lost.
- R7: An immediate length load (`in_vl_imm_set`) writes `min(in_vl_imm, MAX_VL)` on acceptance. The next instruction is accepted on the following edge and already uses the new length.
- R8: A register length load (`in_vl_reg_set`) is issued as a scalar group. After it, `in_ready` stays 0 until the edge on which `wb_vl_valid` is 1. That edge writes `min(wb_vl, MAX_VL)`, and input is accepted again on the next cycle.
- R9: `in_ready` is 0 while `flush` is 1. The edge with `flush` high clears `out_valid`, drops the remaining groups of the current instruction and ends any write-back wait.
- R10: With length equal to `MAX_VL`, the last group has base `MAX_VL-ISSUE_W` and a full mask (defaults: 16 groups, last base 60).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drops the loop in progress, the pending output and the write-back wait |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Stage accepts an instruction this cycle |
| in_tag | input | TAG_W | Instruction identifier carried to every group |
| in_nregs | input | NRW | Decoded number of register operands |
| in_vbits | input | NOPS | Per-operand vector markers |
| in_vl_imm_set | input | 1 | Instruction loads the vector length from `in_vl_imm` |
| in_vl_reg_set | input | 1 | Instruction loads the vector length from a register (write-back later) |
| in_vl_imm | input | VLW | Immediate length value |
| wb_vl_valid | input | 1 | Executed length value is being written back |
| wb_vl | input | VLW | Written-back length value |
| out_valid | output | 1 | Element group present |
| out_ready | input | 1 | Scheduler takes the group |
| out_tag | output | TAG_W | Tag of the issuing instruction |
| out_vector | output | 1 | Group belongs to a vector instruction |
| out_base | output | IDXW | Element index of lane 0 |
| out_mask | output | ISSUE_W | Active lanes |

## Verification
The checker looks at every cycle for these properties: output stability under back-pressure, masks that are contiguous and start at lane 0, the fixed shape of scalar groups, base steps of `ISSUE_W` between consecutive groups of one instruction, the flush effect and the stall after a register length load. Some results cannot be seen from a single cycle and only the directed scenarios show them. These are the exact number of groups and their masks for a given length, the drop of a vector instruction at length zero, the operand-count selection of the vector markers, clamping, the absence of a bubble after an immediate load, and the lengths of the stall windows.

// File: rtl/vl_loop_pkg.sv
package vl_loop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_WAIT = 2'd2
  } loop_st_e;
endpackage

// File: rtl/vns_classify.sv
// Vector-or-scalar decision: one OR tree per operand count, picked by the count.
module vns_classify #(
  parameter int NOPS = 4,
  parameter int NRW  = $clog2(NOPS + 1)
) (
  input  logic [NOPS-1:0] vbits,
  input  logic [NRW-1:0]  nregs,
  output logic            is_vec
);
  logic [NOPS:0] tree;

  assign tree[0] = 1'b0;
  for (genvar k = 1; k <= NOPS; k++) begin : g_tree
    assign tree[k] = |vbits[k-1:0];
  end

  always_comb begin
    if (int'(nregs) <= NOPS) is_vec = tree[nregs];
    else                     is_vec = tree[NOPS];
  end
endmodule

// File: rtl/vl_track.sv
// Vector-length register: immediate loads win over write-backs in the same cycle.
module vl_track #(
  parameter int MAX_VL = 64,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           imm_we,
  input  logic [VLW-1:0] imm_val,
  input  logic           wb_we,
  input  logic [VLW-1:0] wb_val,
  output logic [VLW-1:0] vl
);
  localparam logic [VLW-1:0] VMAX = VLW'(MAX_VL);

  always_ff @(posedge clk) begin
    if (rst)         vl <= '0;
    else if (imm_we) vl <= (imm_val > VMAX) ? VMAX : imm_val;
    else if (wb_we)  vl <= (wb_val > VMAX) ? VMAX : wb_val;
  end
endmodule

// File: rtl/elem_lanes.sv
// Lane mask for one group and whether it is the final group.
module elem_lanes #(
  parameter int ISSUE_W = 4,
  parameter int VLW     = 7
) (
  input  logic [VLW-1:0]     base,
  input  logic [VLW-1:0]     lvl,
  output logic [ISSUE_W-1:0] mask,
  output logic               last
);
  localparam int EW = VLW + 1;

  for (genvar i = 0; i < ISSUE_W; i++) begin : g_lane
    logic [EW-1:0] pos;
    assign pos     = {1'b0, base} + EW'(i);
    assign mask[i] = pos < {1'b0, lvl};
  end

  assign last = ({1'b0, base} + EW'(ISSUE_W)) >= {1'b0, lvl};
endmodule

// File: rtl/vl_loop_stage.sv
module vl_loop_stage #(
  parameter int ISSUE_W = 4,
  parameter int MAX_VL  = 64,
  parameter int NOPS    = 4,
  parameter int TAG_W   = 8,
  parameter int VLW     = $clog2(MAX_VL + 1),
  parameter int IDXW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  parameter int NRW     = $clog2(NOPS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic [NRW-1:0]     in_nregs,
  input  logic [NOPS-1:0]    in_vbits,
  input  logic               in_vl_imm_set,
  input  logic               in_vl_reg_set,
  input  logic [VLW-1:0]     in_vl_imm,
  input  logic               wb_vl_valid,
  input  logic [VLW-1:0]     wb_vl,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [TAG_W-1:0]   out_tag,
  output logic               out_vector,
  output logic [IDXW-1:0]    out_base,
  output logic [ISSUE_W-1:0] out_mask
);
  import vl_loop_pkg::*;

  localparam logic [VLW-1:0] STEP = VLW'(ISSUE_W);

  loop_st_e           st;
  logic [VLW-1:0]     base_q;
  logic [VLW-1:0]     lvl_q;
  logic [TAG_W-1:0]   tag_q;
  logic [VLW-1:0]     vl;
  logic               cls_vec;
  logic               is_vec;
  logic               can_load;
  logic               accept;
  logic [VLW-1:0]     g_base;
  logic [VLW-1:0]     g_lvl;
  logic [ISSUE_W-1:0] g_mask;
  logic               g_last;

  assign can_load = !out_valid || out_ready;
  assign in_ready = (st == ST_IDLE) && can_load && !flush;
  assign accept   = in_valid && in_ready;
  assign is_vec   = cls_vec && !in_vl_imm_set && !in_vl_reg_set;
  assign g_base   = (st == ST_LOOP) ? base_q : '0;
  assign g_lvl    = (st == ST_LOOP) ? lvl_q : vl;

  vns_classify #(.NOPS(NOPS), .NRW(NRW)) cls_i (
    .vbits (in_vbits),
    .nregs (in_nregs),
    .is_vec(cls_vec)
  );

  vl_track #(.MAX_VL(MAX_VL), .VLW(VLW)) vl_i (
    .clk    (clk),
    .rst    (rst),
    .imm_we (accept && in_vl_imm_set),
    .imm_val(in_vl_imm),
    .wb_we  (wb_vl_valid),
    .wb_val (wb_vl),
    .vl     (vl)
  );

  elem_lanes #(.ISSUE_W(ISSUE_W), .VLW(VLW)) lanes_i (
    .base(g_base),
    .lvl (g_lvl),
    .mask(g_mask),
    .last(g_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      base_q     <= '0;
      lvl_q      <= '0;
      tag_q      <= '0;
      out_valid  <= 1'b0;
      out_tag    <= '0;
      out_vector <= 1'b0;
      out_base   <= '0;
      out_mask   <= '0;
    end else if (flush) begin
      st        <= ST_IDLE;
      out_valid <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            if (is_vec && vl == '0) begin
              out_valid <= 1'b0;
            end else if (is_vec) begin
              out_valid  <= 1'b1;
              out_vector <= 1'b1;
              out_base   <= '0;
              out_mask   <= g_mask;
              out_tag    <= in_tag;
              if (!g_last) begin
                st     <= ST_LOOP;
                base_q <= STEP;
                lvl_q  <= vl;
                tag_q  <= in_tag;
              end
            end else begin
              out_valid  <= 1'b1;
              out_vector <= 1'b0;
              out_base   <= '0;
              out_mask   <= ISSUE_W'(1);
              out_tag    <= in_tag;
              if (in_vl_reg_set && !wb_vl_valid) st <= ST_WAIT;
            end
          end else if (can_load) begin
            out_valid <= 1'b0;
          end
        end
        ST_LOOP: begin
          if (can_load) begin
            out_valid  <= 1'b1;
            out_vector <= 1'b1;
            out_base   <= g_base[IDXW-1:0];
            out_mask   <= g_mask;
            out_tag    <= tag_q;
            if (g_last) st <= ST_IDLE;
            else        base_q <= base_q + STEP;
          end
        end
        ST_WAIT: begin
          if (can_load)    out_valid <= 1'b0;
          if (wb_vl_valid) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vl_loop_stage_chk.sv
module vl_loop_stage_chk #(
  parameter int ISSUE_W = 4,
  parameter int TAG_W   = 8,
  parameter int IDXW    = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_vl_reg_set,
  input logic               wb_vl_valid,
  input logic               out_valid,
  input logic               out_ready,
  input logic [TAG_W-1:0]   out_tag,
  input logic               out_vector,
  input logic [IDXW-1:0]    out_base,
  input logic [ISSUE_W-1:0] out_mask
);
  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_base) &&
      $stable(out_mask) && $stable(out_tag) && $stable(out_vector)));

  // R5
  mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mask[0] && ((out_mask & (out_mask + 1'b1)) == '0)));

  // R3
  scalar_once_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_vector) |-> (out_base == '0 && out_mask == ISSUE_W'(1)));

  // R5
  group_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_vector && !flush) |=>
      (!out_valid || !out_vector || out_base == '0 ||
       out_base == $past(out_base) + IDXW'(ISSUE_W)));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  // R9
  flush_block_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);

  // R8
  reg_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_vl_reg_set && !wb_vl_valid) |=> !in_ready);
endmodule

bind vl_loop_stage vl_loop_stage_chk #(
  .ISSUE_W(ISSUE_W), .TAG_W(TAG_W), .IDXW(IDXW)
) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
  .in_vl_reg_set(in_vl_reg_set), .wb_vl_valid(wb_vl_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_tag(out_tag), .out_vector(out_vector),
  .out_base(out_base), .out_mask(out_mask)
);

// File: tb/vl_loop_stage_tb_top.sv
`timescale 1ns/1ps
module vl_loop_stage_tb_top;
  localparam int W = 4;

  typedef struct packed {
    logic       vec;
    logic [7:0] tag;
    logic [5:0] base;
    logic [3:0] mask;
  } grp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_tag = '0;
  logic [2:0] in_nregs = '0;
  logic [3:0] in_vbits = '0;
  logic       in_vl_imm_set = 1'b0;
  logic       in_vl_reg_set = 1'b0;
  logic [6:0] in_vl_imm = '0;
  logic       wb_vl_valid = 1'b0;
  logic [6:0] wb_vl = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_tag;
  logic       out_vector;
  logic [5:0] out_base;
  logic [3:0] out_mask;

  int errors = 0;
  int checks = 0;
  grp_t got[$];
  grp_t exp[$];

  always #10 clk = ~clk;

  vl_loop_stage dut_i (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_nregs(in_nregs), .in_vbits(in_vbits),
    .in_vl_imm_set(in_vl_imm_set), .in_vl_reg_set(in_vl_reg_set), .in_vl_imm(in_vl_imm),
    .wb_vl_valid(wb_vl_valid), .wb_vl(wb_vl), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_vector(out_vector), .out_base(out_base), .out_mask(out_mask)
  );

  always @(negedge clk)
    if (!rst && out_valid && out_ready)
      got.push_back('{vec: out_vector, tag: out_tag, base: out_base, mask: out_mask});

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic exp_scalar(input logic [7:0] tag);
    exp.push_back('{vec: 1'b0, tag: tag, base: 6'd0, mask: 4'b0001});
  endtask

  task automatic exp_vector(input logic [7:0] tag, input int vl);
    for (int b = 0; b < vl; b += W) begin
      logic [3:0] m;
      for (int i = 0; i < W; i++) m[i] = (b + i) < vl;
      exp.push_back('{vec: 1'b1, tag: tag, base: 6'(b), mask: m});
    end
  endtask

  task automatic compare(input string req);
    step(4);
    chk(got.size() == exp.size(), req, "group count", got.size(), exp.size());
    for (int i = 0; i < got.size() && i < exp.size(); i++)
      chk(got[i] == exp[i], req, $sformatf("group %0d (vec,tag,base,mask)", i),
          int'(got[i]), int'(exp[i]));
    got.delete();
    exp.delete();
  endtask

  // Called at posedge+1; returns at posedge+1 after the accepting edge.
  task automatic send(input logic [7:0] tag, input logic [2:0] nr, input logic [3:0] vb,
                      input bit imm, input bit rg, input logic [6:0] vlv, output int waited);
    in_tag = tag; in_nregs = nr; in_vbits = vb;
    in_vl_imm_set = imm; in_vl_reg_set = rg; in_vl_imm = vlv;
    in_valid = 1'b1;
    waited = 0;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); #1;
      waited++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_vl_imm_set = 1'b0; in_vl_reg_set = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_scalar_vl0;
    int w;
    // R3 and R1: VL is 0 after reset, a scalar op still issues once
    send(8'h11, 3'd2, 4'b0000, 1'b0, 1'b0, 7'd0, w);
    exp_scalar(8'h11);
    compare("R3");
  endtask

  task automatic t_vec_zero;
    int w;
    // R4: vector at VL 0 dropped; only the scalar that follows appears
    send(8'h20, 3'd2, 4'b0001, 1'b0, 1'b0, 7'd0, w);
    send(8'h21, 3'd0, 4'b1111, 1'b0, 1'b0, 7'd0, w);
    exp_scalar(8'h21);
    compare("R4");
  endtask

  task automatic t_imm_loop;
    int w;
    // R7: immediate load, next instruction goes without stall
    send(8'h30, 3'd0, 4'b0000, 1'b1, 1'b0, 7'd10, w);
    send(8'h31, 3'd3, 4'b0100, 1'b0, 1'b0, 7'd0, w);
    chk(w == 0, "R7", "stall cycles after immediate load", w, 0);
    exp_scalar(8'h30);
    exp_vector(8'h31, 10);
    compare("R5");
  endtask

  task automatic t_classify;
    int w;
    // R2: marker at operand 2 ignored when only 2 operands, counted with 3
    send(8'h40, 3'd2, 4'b0100, 1'b0, 1'b0, 7'd0, w);
    send(8'h41, 3'd3, 4'b0100, 1'b0, 1'b0, 7'd0, w);
    send(8'h42, 3'd4, 4'b1000, 1'b0, 1'b0, 7'd0, w);
    send(8'h43, 3'd1, 4'b1110, 1'b0, 1'b0, 7'd0, w);
    send(8'h44, 3'd0, 4'b1111, 1'b1, 1'b0, 7'd8, w);
    send(8'h45, 3'd1, 4'b0001, 1'b0, 1'b0, 7'd0, w);
    exp_scalar(8'h40);
    exp_vector(8'h41, 10);
    exp_vector(8'h42, 10);
    exp_scalar(8'h43);
    exp_scalar(8'h44);
    exp_vector(8'h45, 8);
    compare("R2");
  endtask

  task automatic t_backpressure;
    int w;
    // R6: groups survive an irregular ready pattern
    fork
      begin
        send(8'h50, 3'd1, 4'b0001, 1'b0, 1'b0, 7'd0, w);
        send(8'h51, 3'd1, 4'b0000, 1'b0, 1'b0, 7'd0, w);
      end
      begin
        for (int c = 0; c < 20; c++) begin
          out_ready = (c % 3) == 1;
          @(posedge clk); #1;
        end
        out_ready = 1'b1;
      end
    join
    exp_vector(8'h50, 8);
    exp_scalar(8'h51);
    compare("R6");
  endtask

  task automatic t_reg_stall;
    int w;
    int lowc;
    // R8: register load stalls until write-back
    send(8'h60, 3'd1, 4'b0000, 1'b0, 1'b1, 7'd0, w);
    lowc = 0;
    repeat (5) begin
      @(negedge clk);
      if (!in_ready) lowc++;
      @(posedge clk); #1;
    end
    chk(lowc == 5, "R8", "cycles with in_ready low before write-back", lowc, 5);
    wb_vl = 7'd3; wb_vl_valid = 1'b1;
    @(posedge clk); #1;
    wb_vl_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8", "in_ready after write-back", in_ready, 1);
    @(posedge clk); #1;
    send(8'h61, 3'd2, 4'b0010, 1'b0, 1'b0, 7'd0, w);
    exp_scalar(8'h60);
    exp_vector(8'h61, 3);
    compare("R8");
  endtask

  task automatic t_flush;
    int w;
    // R9: flush mid-loop under back-pressure
    send(8'h70, 3'd0, 4'b0000, 1'b1, 1'b0, 7'd20, w);
    step(2);
    got.delete();
    out_ready = 1'b0;
    send(8'h71, 3'd1, 4'b0001, 1'b0, 1'b0, 7'd0, w);
    step(2);
    flush = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R9", "in_ready during flush", in_ready, 0);
    @(posedge clk); #1;
    flush = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after flush", out_valid, 0);
    @(posedge clk); #1;
    out_ready = 1'b1;
    step(3);
    chk(got.size() == 0, "R9", "groups after flush", got.size(), 0);
    // flush also ends a write-back wait
    send(8'h72, 3'd1, 4'b0000, 1'b0, 1'b1, 7'd0, w);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", "in_ready after flush during wait", in_ready, 1);
    @(posedge clk); #1;
    got.delete();
  endtask

  task automatic t_max;
    int w;
    // R10 with R7 clamp: 100 saturates to 64
    send(8'h80, 3'd0, 4'b0000, 1'b1, 1'b0, 7'd100, w);
    send(8'h81, 3'd4, 4'b0001, 1'b0, 1'b0, 7'd0, w);
    step(20);
    exp_scalar(8'h80);
    exp_vector(8'h81, 64);
    compare("R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    @(posedge clk); #1;
    t_scalar_vl0();
    t_vec_zero();
    t_imm_loop();
    t_classify();
    t_backpressure();
    t_reg_stall();
    t_flush();
    t_max();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule